// File: doc/BRIEF.md
# Indirect Interrupt-Controller Register Window

This block is the software-visible register interface of an I/O interrupt controller. A processor reaches it through a small single-cycle register bus with three direct locations: a select register that holds an 8-bit index, a data window that reads or writes whichever internal register the index names, and an end-of-interrupt location. Behind the window are a read-only version word that reports the number of table entries, a 4-bit controller identifier (with a read-only alias), and a redirection table holding one 64-bit entry per input pin. Each entry is reached as two 32-bit halves.

The redirection table is stored inside the block. The remote-IRR status bit of each entry belongs to the trigger logic, which sets and clears it through per-pin strobes; software writes leave it untouched, and the delivery-status bit always reads as zero. A write to the end-of-interrupt location is forwarded to the trigger logic as a one-cycle pulse carrying the vector. Delivery and trigger handling are done by neighbouring blocks.

Top module: `irq_regwin`

## Requirements
- R1: Direct offsets are 0x00 (select), 0x10 (window) and 0x40 (end-of-interrupt). A read of any other offset returns zero and a write to it changes no state.
- R2: Read data appears on `rsp_rdata` in the cycle after the read request and holds its value until the next read request.
- R3: Reading the select offset returns the last index written to it in bits 7:0, with bits 31:8 zero.
- R4: Window index 0x01 reads the version word: version code in bits 7:0, pin count minus one in bits 23:16, all other bits zero. Window writes at this index are ignored.
- R5: A window write at index 0x00 stores write-data bits 27:24 as the identifier. Indices 0x00 and 0x02 both read the identifier in bits 27:24 with all other bits zero; writes at index 0x02 are ignored.
- R6: Index 0x10 + 2n addresses the lower half of entry n and index 0x11 + 2n its upper half; the upper half reads the 8-bit destination in bits 31:24, other bits zero.
- R7: Indices 0x03 to 0x0F and indices at or above 0x10 + 2 x pin count read as zero and ignore writes.
- R8: A write to an upper half replaces only the destination (write-data bits 31:24) and leaves the lower half unchanged.
- R9: A write to a lower half stores all 32 bits of write data except bit 14 (remote IRR), which keeps its current value, and bit 12 (delivery status), which becomes zero. Field layout: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13, remote IRR 14, trigger mode 15, mask 16.
- R10: A pulse on `rirr_set[n]` sets bit 14 of entry n, a pulse on `rirr_clr[n]` clears it, and set wins when both are active; the change is visible to a read issued in the following cycle.
- R11: With a version code of 0x20 or more, a write to offset 0x40 raises `eoi_valid` for exactly one cycle, in the cycle after the write, with `eoi_vector` equal to write-data bits 7:0; reads of 0x40 return zero.
- R12: After reset every lower half reads 0x0001_0000 (mask set), every destination is zero, the identifier and select index are zero, `rsp_rdata` is zero and `eoi_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Direct register offset |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the read request |
| rirr_set | input | NUM_PINS | Per-pin remote-IRR set strobes from trigger logic |
| rirr_clr | input | NUM_PINS | Per-pin remote-IRR clear strobes from trigger logic |
| eoi_valid | output | 1 | End-of-interrupt pulse |
| eoi_vector | output | 8 | Vector written with the end-of-interrupt pulse |

## Verification
On every cycle the assertions check that reads of unmapped offsets return zero, that read data holds between reads, that the end-of-interrupt pulse follows exactly the writes to its offset and carries their vector, that a selected version read returns the computed word, and that the select register reads back the index just written. Field rules that need history across several accesses, such as remote-IRR preservation through lower-half writes, destination-only upper writes, the set-over-clear priority and the silence of out-of-range indices, are shown only by the bench scenarios, which compare every window read with a model of the table.

// File: rtl/irq_regwin_pkg.sv
// Shared constants and types for the indirect register window.
// Assumes an 8-bit direct offset and an 8-bit select index.
package irq_regwin_pkg;

    // Direct offsets on the register bus
    localparam logic [7:0] OFS_SELECT = 8'h00;
    localparam logic [7:0] OFS_WINDOW = 8'h10;
    localparam logic [7:0] OFS_EOI    = 8'h40;

    // Window indices
    localparam logic [7:0] IDX_IDENT   = 8'h00;
    localparam logic [7:0] IDX_VERSION = 8'h01;
    localparam logic [7:0] IDX_ARBIT   = 8'h02;
    localparam logic [7:0] IDX_TABLE0  = 8'h10;

    // Identifier field position
    localparam int ID_LSB = 24;
    localparam int ID_W   = 4;

    // Lower-half field positions
    localparam int BIT_DSTAT = 12;
    localparam int BIT_RIRR  = 14;
    localparam int BIT_MASK  = 16;
    localparam int DEST_LSB  = 24;   // destination inside the upper half
    localparam int DEST_W    = 8;

    localparam logic [31:0] LO_RESET = 32'(1) << BIT_MASK;

    // What the current select index points at
    typedef enum logic [2:0] {
        WK_NONE,
        WK_IDENT,
        WK_VERSION,
        WK_ARBIT,
        WK_ENTRY
    } win_kind_e;

endpackage

// File: rtl/irq_regwin_decode.sv
// Address and index decoder.
// Classifies the direct offset of a request and the register named by the
// select index. Purely combinational; assumes NUM_PINS <= 120.
module irq_regwin_decode
    import irq_regwin_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter bit EOI_EN   = 1'b1,
    localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic [7:0]       addr,
    input  logic [7:0]       sel,
    output logic             hit_sel,
    output logic             hit_win,
    output logic             hit_eoi,
    output win_kind_e        kind,
    output logic [IDX_W-1:0] entry_idx,
    output logic             entry_hi
);

    localparam logic [7:0] PIN_CNT8 = 8'(NUM_PINS);

    logic [7:0] rel;
    logic [6:0] num;

    // Direct-offset match
    always_comb begin
        hit_sel = (addr == OFS_SELECT);
        hit_win = (addr == OFS_WINDOW);
        hit_eoi = EOI_EN && (addr == OFS_EOI);
    end

    // Index classification and entry number
    always_comb begin
        rel       = sel - IDX_TABLE0;
        num       = rel[7:1];
        entry_hi  = rel[0];
        entry_idx = num[IDX_W-1:0];
        if (sel == IDX_IDENT)
            kind = WK_IDENT;
        else if (sel == IDX_VERSION)
            kind = WK_VERSION;
        else if (sel == IDX_ARBIT)
            kind = WK_ARBIT;
        else if (sel >= IDX_TABLE0 && {1'b0, num} < PIN_CNT8)
            kind = WK_ENTRY;
        else
            kind = WK_NONE;
    end

endmodule

// File: rtl/irq_regwin_entry.sv
// One redirection-table entry.
// Holds the 32-bit lower half and the 8-bit destination. Software writes
// keep remote IRR and zero delivery status; trigger strobes own remote IRR.
module irq_regwin_entry
    import irq_regwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        rirr_set,
    input  logic        rirr_clr,
    output logic [31:0] lo_word,
    output logic [31:0] hi_word
);

    localparam logic [31:0] KEEP_MASK = 32'(1) << BIT_RIRR;
    localparam logic [31:0] ZERO_MASK = 32'(1) << BIT_DSTAT;

    logic [31:0]       lo_q, lo_n;
    logic [DEST_W-1:0] dest_q;

    // Next lower half: software field rules, then trigger strobes
    always_comb begin
        lo_n = lo_q;
        if (wr_lo)
            lo_n = (wdata & ~(KEEP_MASK | ZERO_MASK)) | (lo_q & KEEP_MASK);
        if (rirr_set)
            lo_n[BIT_RIRR] = 1'b1;
        else if (rirr_clr)
            lo_n[BIT_RIRR] = 1'b0;
    end

    // Entry storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= LO_RESET;
            dest_q <= '0;
        end else begin
            lo_q <= lo_n;
            if (wr_hi)
                dest_q <= wdata[DEST_LSB +: DEST_W];
        end
    end

    // Read views
    always_comb begin
        lo_word = lo_q;
        hi_word = {dest_q, 24'h0};
    end

endmodule

// File: rtl/irq_regwin_readmux.sv
// Read-data selector.
// Picks the value a read returns from the decoded target. Unmapped offsets
// and unimplemented indices give zero.
module irq_regwin_readmux
    import irq_regwin_pkg::*;
#(
    parameter int          NUM_PINS     = 24,
    parameter logic [7:0]  VERSION_CODE = 8'h20,
    localparam int         IDX_W        = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                         hit_sel,
    input  logic                         hit_win,
    input  win_kind_e                    kind,
    input  logic [IDX_W-1:0]             entry_idx,
    input  logic                         entry_hi,
    input  logic [7:0]                   sel,
    input  logic [ID_W-1:0]              ident,
    input  logic [NUM_PINS-1:0][31:0]    lo_words,
    input  logic [NUM_PINS-1:0][31:0]    hi_words,
    output logic [31:0]                  rdata
);

    localparam logic [31:0] VERSION_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION_CODE};

    logic [31:0] entry_word;

    // Entry half selection by index match
    always_comb begin
        entry_word = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (entry_idx == IDX_W'(p))
                entry_word = entry_hi ? hi_words[p] : lo_words[p];
        end
    end

    // Final read value
    always_comb begin
        rdata = '0;
        if (hit_sel) begin
            rdata = {24'h0, sel};
        end else if (hit_win) begin
            case (kind)
                WK_IDENT, WK_ARBIT: rdata = 32'(ident) << ID_LSB;
                WK_VERSION:         rdata = VERSION_WORD;
                WK_ENTRY:           rdata = entry_word;
                default:            rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_regwin.sv
// Indirect interrupt-controller register window (top).
// Single-cycle register bus with one-cycle read latency; holds the select
// index, identifier and redirection table, and forwards end-of-interrupt
// writes as a pulse. Assumes requests never stall.
module irq_regwin
    import irq_regwin_pkg::*;
#(
    parameter int         NUM_PINS     = 24,
    parameter logic [7:0] VERSION_CODE = 8'h20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [7:0]          req_addr,
    input  logic [31:0]         req_wdata,
    output logic [31:0]         rsp_rdata,
    input  logic [NUM_PINS-1:0] rirr_set,
    input  logic [NUM_PINS-1:0] rirr_clr,
    output logic                eoi_valid,
    output logic [7:0]          eoi_vector
);

    localparam int IDX_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam bit EOI_EN = (VERSION_CODE >= 8'h20);

    logic [7:0]             sel_q;
    logic [ID_W-1:0]        ident_q;
    logic [31:0]            rdata_q;
    logic                   hit_sel, hit_win, hit_eoi;
    win_kind_e              kind;
    logic [IDX_W-1:0]       entry_idx;
    logic                   entry_hi;
    logic                   wr_any, rd_any, win_wr;
    logic [NUM_PINS-1:0][31:0] lo_words, hi_words;
    logic [31:0]            rd_value;

    irq_regwin_decode #(.NUM_PINS(NUM_PINS), .EOI_EN(EOI_EN)) dec_i (
        .addr      (req_addr),
        .sel       (sel_q),
        .hit_sel   (hit_sel),
        .hit_win   (hit_win),
        .hit_eoi   (hit_eoi),
        .kind      (kind),
        .entry_idx (entry_idx),
        .entry_hi  (entry_hi)
    );

    // Request qualification
    always_comb begin
        wr_any = req_valid && req_write;
        rd_any = req_valid && !req_write;
        win_wr = wr_any && hit_win;
    end

    // Select index and identifier registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            ident_q <= '0;
        end else begin
            if (wr_any && hit_sel)
                sel_q <= req_wdata[7:0];
            if (win_wr && kind == WK_IDENT)
                ident_q <= req_wdata[ID_LSB +: ID_W];
        end
    end

    // Redirection table, one entry per pin
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_entry
        logic hit_p;
        assign hit_p = win_wr && (kind == WK_ENTRY) && (entry_idx == IDX_W'(p));
        irq_regwin_entry ent_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (hit_p && !entry_hi),
            .wr_hi    (hit_p && entry_hi),
            .wdata    (req_wdata),
            .rirr_set (rirr_set[p]),
            .rirr_clr (rirr_clr[p]),
            .lo_word  (lo_words[p]),
            .hi_word  (hi_words[p])
        );
    end

    irq_regwin_readmux #(.NUM_PINS(NUM_PINS), .VERSION_CODE(VERSION_CODE)) mux_i (
        .hit_sel   (hit_sel),
        .hit_win   (hit_win),
        .kind      (kind),
        .entry_idx (entry_idx),
        .entry_hi  (entry_hi),
        .sel       (sel_q),
        .ident     (ident_q),
        .lo_words  (lo_words),
        .hi_words  (hi_words),
        .rdata     (rd_value)
    );

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd_any)
            rdata_q <= rd_value;
    end

    assign rsp_rdata = rdata_q;

    // End-of-interrupt forwarding, present only for newer version codes
    if (EOI_EN) begin : g_eoi
        logic       eoi_q;
        logic [7:0] vec_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                eoi_q <= 1'b0;
                vec_q <= '0;
            end else begin
                eoi_q <= wr_any && hit_eoi;
                if (wr_any && hit_eoi)
                    vec_q <= req_wdata[7:0];
            end
        end
        assign eoi_valid  = eoi_q;
        assign eoi_vector = vec_q;
    end else begin : g_no_eoi
        assign eoi_valid  = 1'b0;
        assign eoi_vector = 8'h00;
    end

endmodule

// File: rtl/irq_regwin_chk.sv
// Protocol checker for irq_regwin, attached by bind.
// Observes the bus ports, the pulse outputs and the select register.
module irq_regwin_chk #(
    parameter int         NUM_PINS     = 24,
    parameter logic [7:0] VERSION_CODE = 8'h20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [7:0]  req_addr,
    input logic [31:0] req_wdata,
    input logic [31:0] rsp_rdata,
    input logic        eoi_valid,
    input logic [7:0]  eoi_vector,
    input logic [7:0]  sel_q
);

    localparam bit EOI_ON = (VERSION_CODE >= 8'h20);
    localparam logic [31:0] VER_EXP = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION_CODE};

    logic mapped;
    assign mapped = (req_addr == 8'h00) || (req_addr == 8'h10);

    // R1: unmapped reads return zero
    p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !mapped) |=> (rsp_rdata == 32'h0));

    // R2: read data holds when no read is issued
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> $stable(rsp_rdata));

    // R3: select read returns the held index
    p_sel_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == 8'h00) |=> (rsp_rdata == {24'h0, $past(sel_q)}));

    // R4: version word contents
    p_version_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == 8'h10 && sel_q == 8'h01) |=> (rsp_rdata == VER_EXP));

    // R11: pulse follows each end-of-interrupt write with its vector
    p_eoi_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (EOI_ON && req_valid && req_write && req_addr == 8'h40)
        |=> (eoi_valid && eoi_vector == $past(req_wdata[7:0])));

    // R11: no pulse without such a write
    p_eoi_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(EOI_ON && req_valid && req_write && req_addr == 8'h40) |=> !eoi_valid);

endmodule

bind irq_regwin irq_regwin_chk #(.NUM_PINS(NUM_PINS), .VERSION_CODE(VERSION_CODE)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_rdata  (rsp_rdata),
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .sel_q      (sel_q)
);

// File: tb/irq_regwin_tb_top.sv
// Bench for irq_regwin: directed corner cases then seeded random traffic,
// each window read compared with a bench model of the register file.
module irq_regwin_tb_top;

    localparam int         NP  = 24;
    localparam logic [7:0] VER = 8'h20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [7:0]    req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [31:0]   rsp_rdata;
    logic [NP-1:0] rirr_set = '0;
    logic [NP-1:0] rirr_clr = '0;
    logic          eoi_valid;
    logic [7:0]    eoi_vector;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model
    logic [31:0] m_lo [NP];
    logic [7:0]  m_dest [NP];
    logic [3:0]  m_id;
    logic [7:0]  m_sel;

    always #5 clk = ~clk;

    irq_regwin #(.NUM_PINS(NP), .VERSION_CODE(VER)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .rirr_set(rirr_set), .rirr_clr(rirr_clr),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
    );

    function automatic logic [31:0] exp_window(input logic [7:0] s);
        int n;
        if (s == 8'h00 || s == 8'h02) return {4'h0, m_id, 24'h0};
        if (s == 8'h01) return {8'h00, 8'(NP - 1), 8'h00, VER};
        if (s < 8'h10) return 32'h0;
        n = (int'(s) - 16) / 2;
        if (n >= NP) return 32'h0;
        return s[0] ? {m_dest[n], 24'h0} : m_lo[n];
    endfunction

    function automatic string tag_of(input logic [7:0] s);
        if (s == 8'h01) return "R4";
        if (s == 8'h00 || s == 8'h02) return "R5";
        if (s < 8'h10 || (int'(s) - 16) / 2 >= NP) return "R7";
        return s[0] ? "R8" : "R9";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic model_win_write(input logic [31:0] d);
        int n;
        if (m_sel == 8'h00) m_id = d[27:24];
        else if (m_sel >= 8'h10 && (int'(m_sel) - 16) / 2 < NP) begin
            n = (int'(m_sel) - 16) / 2;
            if (m_sel[0]) m_dest[n] = d[31:24];
            else m_lo[n] = (d & ~32'h0000_5000) | (m_lo[n] & 32'h0000_4000);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        if (a == 8'h00) m_sel = d[7:0];
        else if (a == 8'h10) model_win_write(d);
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string req);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, rsp_rdata, exp);
    endtask

    task automatic win_read();
        bus_read(8'h10, exp_window(m_sel), tag_of(m_sel));
    endtask

    task automatic strobe(input logic [NP-1:0] s, input logic [NP-1:0] c);
        rirr_set = s; rirr_clr = c;
        @(negedge clk);
        rirr_set = '0; rirr_clr = '0;
        for (int p = 0; p < NP; p++) begin
            if (s[p]) m_lo[p][14] = 1'b1;
            else if (c[p]) m_lo[p][14] = 1'b0;
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20240611));
        for (int p = 0; p < NP; p++) begin
            m_lo[p] = 32'h0001_0000;
            m_dest[p] = 8'h00;
        end
        m_id = '0;
        m_sel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        check("R12 rdata", rsp_rdata, 32'h0);
        check("R12 eoi", {31'h0, eoi_valid}, 32'h0);
        bus_read(8'h00, 32'h0, "R12 select");
        for (int p = 0; p < NP; p++) begin
            bus_write(8'h00, 32'(16 + 2 * p));
            bus_read(8'h10, 32'h0001_0000, "R12 lower");
            bus_write(8'h00, 32'(17 + 2 * p));
            bus_read(8'h10, 32'h0, "R12 upper");
        end
        bus_write(8'h00, 32'h0);
        bus_read(8'h10, 32'h0, "R12 ident");

        // R3: select readback
        bus_write(8'h00, 32'hFFFF_FF37);
        bus_read(8'h00, 32'h0000_0037, "R3 select");

        // R4: version word, write ignored
        bus_write(8'h00, 32'h01);
        bus_read(8'h10, 32'h0017_0020, "R4 version");
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_read(8'h10, 32'h0017_0020, "R4 write ignored");

        // R5: identifier and arbitration alias
        bus_write(8'h00, 32'h00);
        bus_write(8'h10, 32'hFA5A_5A5A);
        bus_read(8'h10, 32'h0A00_0000, "R5 ident");
        bus_write(8'h00, 32'h02);
        bus_read(8'h10, 32'h0A00_0000, "R5 arbitration alias");
        bus_write(8'h10, 32'h0300_0000);
        bus_read(8'h10, 32'h0A00_0000, "R5 arbitration write ignored");

        // R9, R8: lower/upper field rules on entry 3
        bus_write(8'h00, 32'h16);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_read(8'h10, 32'hFFFF_AFFF, "R9 lower write");
        bus_write(8'h00, 32'h17);
        bus_write(8'h10, 32'h1234_5678);
        bus_read(8'h10, 32'h1200_0000, "R8 upper write");
        bus_write(8'h00, 32'h16);
        bus_read(8'h10, 32'hFFFF_AFFF, "R8 lower unchanged");

        // R10: remote IRR strobes, then R9 preservation
        strobe(NP'(1) << 3, '0);
        bus_read(8'h10, 32'hFFFF_EFFF, "R10 set");
        bus_write(8'h10, 32'h0000_0000);
        bus_read(8'h10, 32'h0000_4000, "R9 remote IRR kept");
        strobe(NP'(1) << 3, NP'(1) << 3);
        bus_read(8'h10, 32'h0000_4000, "R10 set wins");
        strobe('0, NP'(1) << 3);
        bus_read(8'h10, 32'h0000_0000, "R10 clear");

        // R6: last entry halves
        bus_write(8'h00, 32'h3E);
        bus_write(8'h10, 32'h0000_80C1);
        bus_write(8'h00, 32'h3F);
        bus_write(8'h10, 32'hC300_0000);
        bus_read(8'h10, 32'hC300_0000, "R6 last upper");
        bus_write(8'h00, 32'h3E);
        bus_read(8'h10, 32'h0000_80C1, "R6 last lower");

        // R7: out-of-range indices
        bus_write(8'h00, 32'h40);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_read(8'h10, 32'h0, "R7 past table");
        bus_write(8'h00, 32'h05);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_read(8'h10, 32'h0, "R7 reserved index");
        bus_write(8'h00, 32'h10);
        bus_read(8'h10, 32'h0001_0000, "R7 entry 0 untouched");

        // R1: unmapped offsets
        bus_write(8'h04, 32'h0000_0099);
        bus_read(8'h00, 32'h0000_0010, "R1 write ignored");
        bus_read(8'h20, 32'h0, "R1 unmapped read");

        // R2: hold between reads
        bus_read(8'h00, 32'h0000_0010, "R2 read");
        held = rsp_rdata;
        bus_write(8'h00, 32'h11);
        repeat (2) @(negedge clk);
        check("R2 hold", rsp_rdata, held);

        // R11: end-of-interrupt pulse
        bus_write(8'h40, 32'h1234_56AB);
        check("R11 pulse", {31'h0, eoi_valid}, 32'h1);
        check("R11 vector", {24'h0, eoi_vector}, 32'h0000_00AB);
        @(negedge clk);
        check("R11 single cycle", {31'h0, eoi_valid}, 32'h0);
        bus_read(8'h40, 32'h0, "R11 read zero");

        // Random traffic
        for (int it = 0; it < 600; it++) begin
            int op;
            op = int'($urandom % 5);
            case (op)
                0: begin
                    bus_write(8'h00, ($urandom % 4 == 0) ? $urandom : 32'($urandom % 64));
                    bus_read(8'h00, {24'h0, m_sel}, "R3 random select");
                end
                1: bus_write(8'h10, $urandom);
                2: win_read();
                3: strobe(NP'($urandom), NP'($urandom));
                default: begin
                    logic [31:0] d;
                    d = $urandom;
                    bus_write(8'h40, d);
                    check("R11 random vector", {23'h0, eoi_valid, eoi_vector}, {23'h0, 1'b1, d[7:0]});
                end
            endcase
        end
        for (int s = 0; s < 64; s++) begin
            bus_write(8'h00, 32'(s));
            win_read();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule